// File: doc/BRIEF.md
# Power-Mode Output Controller

This block turns one general-purpose control pin into the enables that gate a clock generator's outputs and synthesis loops. A configuration field gives the pin one of three meanings. It can be a plain output enable. It can be a full power-down. It can be a selective suspend that stops only a chosen set of PLLs and outputs. While the pin is high, every output and PLL that configuration enables runs normally.

In suspend mode, a PLL mask and an output mask pick what stops. The controller also reads the routing that connects each output to its source. Any output fed from a suspended PLL is forced into suspend, and a configuration-error flag is raised when the output mask left it running. After a full power-down ends, all outputs stay three-stated for a programmable number of reference cycles so that the PLLs can relock. The control pin passes through a two-flop synchronizer on the reference clock before it is decoded.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With mode code 0 (output enable), or the reserved code 3, and the synchronized pin low, all output enables are 0. The PLL enables equal their configured values, and the counter and oscillator enables are 1.
- R2: With mode code 1 (shutdown) and the synchronized pin low, the output, PLL, counter and oscillator enables are all 0.
- R3: When the shutdown condition ends, relock_wait_o is high and all outputs are three-stated for exactly relock_cycles_i reference cycles. The wait begins in the cycle the condition ends. A value of 0 gives no wait.
- R4: With mode code 2 (suspend) and the synchronized pin low, PLL k is enabled only if it is configured on and bit k of the PLL mask is 0. Output i is enabled only if it is configured on and is not suspended. The counter and oscillator stay enabled.
- R5: Output i takes its source from out_src_i[2i+1:2i]: 0 is the reference and values 1 to 3 select PLL 0 to 2. In suspend mode with the pin low, an output routed from a masked PLL is three-stated even when its own mask bit is 0.
- R6: In suspend mode, cfg_err_o is 1 exactly when some output is routed from a masked PLL while its own output-mask bit is 0. In the other modes cfg_err_o is 0.
- R7: With the synchronized pin high and no relock wait active, output and PLL enables equal their configured values in every mode, and the counter and oscillator enables are 1.
- R8: A change on the pin reaches the enables after the second rising reference edge, not after the first. During reset the synchronizer holds the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_pin_i | input | 1 | Asynchronous general-purpose control pin |
| mode_i | input | 2 | Pin meaning: 0 output enable, 1 shutdown, 2 suspend, 3 as 0 |
| out_cfg_en_i | input | 3 | Outputs enabled by configuration |
| pll_cfg_en_i | input | 3 | PLLs enabled by configuration |
| out_src_i | input | 6 | Two-bit source code per output |
| susp_pll_mask_i | input | 3 | PLLs stopped in suspend |
| susp_out_mask_i | input | 3 | Outputs stopped in suspend |
| relock_cycles_i | input | 16 | Relock wait length in reference cycles |
| out_oe_o | output | 3 | Output drive enables (0 = three-state) |
| pll_en_o | output | 3 | PLL run enables |
| cnt_en_o | output | 1 | Divider counter enable |
| osc_en_o | output | 1 | Reference oscillator enable |
| cfg_err_o | output | 1 | Suspend mask breaks routing dependency |
| relock_wait_o | output | 1 | Relock wait in progress |

## Verification
Some rules are checked on every cycle. These are the decode of the low pin in output-enable and shutdown modes, the three-stating of every output that depends on a masked PLL, the quiet outputs during relock, and the confinement of the error flag to suspend mode. Other behaviour needs the bench's scenarios to show it. This covers the exact length of the relock window for a given count and for zero, and the two-edge synchronizer latency. It also covers the error flag against hand-built routings and the restoration of configured enables when the pin returns high. Random configurations are compared against a bench model of all four modes.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_OE   = 2'd0,
    MODE_SHDN = 2'd1,
    MODE_SUSP = 2'd2,
    MODE_RSVD = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwr_dep_check.sv
module pwr_dep_check #(
  parameter int N_OUT = 3,
  parameter int N_PLL = 3,
  parameter int SRC_W = 2
) (
  input  logic [N_OUT*SRC_W-1:0] out_src_i,
  input  logic [N_PLL-1:0]       pll_mask_i,
  input  logic [N_OUT-1:0]       out_mask_i,
  output logic [N_OUT-1:0]       eff_mask_o,
  output logic                   viol_o
);
  logic [N_OUT-1:0] forced;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [SRC_W-1:0] src;
    assign src = out_src_i[i*SRC_W +: SRC_W];
    always_comb begin
      forced[i] = 1'b0;
      for (int k = 0; k < N_PLL; k++) begin
        if (src == SRC_W'(k + 1) && pll_mask_i[k]) forced[i] = 1'b1;
      end
    end
  end

  assign eff_mask_o = out_mask_i | forced;
  assign viol_o     = |(forced & ~out_mask_i);
endmodule

// File: rtl/pwr_relock_timer.sv
module pwr_relock_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shdn_i,
  input  logic [CW-1:0] load_val_i,
  output logic          wait_o
);
  logic          shdn_q;
  logic [CW-1:0] cnt_q;
  logic          end_pulse;

  assign end_pulse = shdn_q & ~shdn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shdn_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      shdn_q <= shdn_i;
      if (shdn_i)              cnt_q <= '0;
      else if (end_pulse)      cnt_q <= (load_val_i == '0) ? '0 : load_val_i - 1'b1;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  // load cycle counts as the first wait cycle
  assign wait_o = (cnt_q != '0) | (end_pulse & (load_val_i != '0));

  assert_relock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_i && cnt_q > CW'(1)) |=> (wait_o || shdn_i));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int N_OUT    = 3,
  parameter int N_PLL    = 3,
  parameter int RELOCK_W = 16,
  parameter int SYNC_STG = 2,
  localparam int SRC_W   = $clog2(N_PLL + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctl_pin_i,
  input  logic [1:0]             mode_i,
  input  logic [N_OUT-1:0]       out_cfg_en_i,
  input  logic [N_PLL-1:0]       pll_cfg_en_i,
  input  logic [N_OUT*SRC_W-1:0] out_src_i,
  input  logic [N_PLL-1:0]       susp_pll_mask_i,
  input  logic [N_OUT-1:0]       susp_out_mask_i,
  input  logic [RELOCK_W-1:0]    relock_cycles_i,
  output logic [N_OUT-1:0]       out_oe_o,
  output logic [N_PLL-1:0]       pll_en_o,
  output logic                   cnt_en_o,
  output logic                   osc_en_o,
  output logic                   cfg_err_o,
  output logic                   relock_wait_o
);
  pin_mode_e        mode;
  logic             pin_s;
  logic             pin_low;
  logic             shdn_now;
  logic             susp_now;
  logic [N_OUT-1:0] eff_mask;
  logic             viol;

  assign mode     = pin_mode_e'(mode_i);
  assign pin_low  = ~pin_s;
  assign shdn_now = (mode == MODE_SHDN) && pin_low;
  assign susp_now = (mode == MODE_SUSP) && pin_low;

  pwr_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_pin_i),
    .q_o   (pin_s)
  );

  pwr_dep_check #(.N_OUT(N_OUT), .N_PLL(N_PLL), .SRC_W(SRC_W)) u_dep (
    .out_src_i (out_src_i),
    .pll_mask_i(susp_pll_mask_i),
    .out_mask_i(susp_out_mask_i),
    .eff_mask_o(eff_mask),
    .viol_o    (viol)
  );

  pwr_relock_timer #(.CW(RELOCK_W)) u_relock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shdn_i    (shdn_now),
    .load_val_i(relock_cycles_i),
    .wait_o    (relock_wait_o)
  );

  always_comb begin
    out_oe_o = out_cfg_en_i;
    pll_en_o = pll_cfg_en_i;
    cnt_en_o = 1'b1;
    osc_en_o = 1'b1;
    if (shdn_now) begin
      out_oe_o = '0;
      pll_en_o = '0;
      cnt_en_o = 1'b0;
      osc_en_o = 1'b0;
    end else if (susp_now) begin
      pll_en_o = pll_cfg_en_i & ~susp_pll_mask_i;
      out_oe_o = out_cfg_en_i & ~eff_mask;
    end else if (pin_low) begin
      out_oe_o = '0;
    end
    if (relock_wait_o) out_oe_o = '0;
  end

  assign cfg_err_o = (mode == MODE_SUSP) && viol;

  assert_oe_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd0 || mode_i == 2'd3) && !pin_s) |->
      (out_oe_o == '0 && pll_en_o == pll_cfg_en_i && cnt_en_o && osc_en_o));

  assert_shdn_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !pin_s) |->
      (out_oe_o == '0 && pll_en_o == '0 && !cnt_en_o && !osc_en_o));

  assert_relock_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_wait_o |-> (out_oe_o == '0));

  assert_err_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (mode_i == 2'd2));

  for (genvar i = 0; i < N_OUT; i++) begin : g_dep_chk
    for (genvar k = 0; k < N_PLL; k++) begin : g_pll
      assert_dep_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd2 && !pin_s && susp_pll_mask_i[k] &&
         out_src_i[i*SRC_W +: SRC_W] == SRC_W'(k + 1)) |-> !out_oe_o[i]);
    end
  end
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin;
  logic [1:0]  mode;
  logic [2:0]  out_cfg, pll_cfg, pll_mask, out_mask;
  logic [5:0]  src;
  logic [15:0] relock;
  logic [2:0]  out_oe, pll_en;
  logic        cnt_en, osc_en, cfg_err, rwait;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_pin_i(pin), .mode_i(mode),
    .out_cfg_en_i(out_cfg), .pll_cfg_en_i(pll_cfg), .out_src_i(src),
    .susp_pll_mask_i(pll_mask), .susp_out_mask_i(out_mask),
    .relock_cycles_i(relock), .out_oe_o(out_oe), .pll_en_o(pll_en),
    .cnt_en_o(cnt_en), .osc_en_o(osc_en), .cfg_err_o(cfg_err),
    .relock_wait_o(rwait)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model of the settled enables (no relock window)
  function automatic logic [10:0] model(input logic [1:0] m, input logic p);
    logic [2:0] forced, oe, pe;
    logic c, o, e;
    forced = '0;
    for (int i = 0; i < 3; i++) begin
      logic [1:0] s;
      s = src[2*i +: 2];
      if (s != 0 && pll_mask[s-1]) forced[i] = 1'b1;
    end
    e  = (m == 2'd2) && |(forced & ~out_mask);
    oe = out_cfg; pe = pll_cfg; c = 1'b1; o = 1'b1;
    if (!p) begin
      case (m)
        2'd1: begin oe = '0; pe = '0; c = 1'b0; o = 1'b0; end
        2'd2: begin pe = pll_cfg & ~pll_mask; oe = out_cfg & ~(out_mask | forced); end
        default: oe = '0;
      endcase
    end
    return {oe, pe, c, o, e};
  endfunction

  function automatic logic [10:0] dut_vec();
    return {out_oe, pll_en, cnt_en, osc_en, cfg_err};
  endfunction

  task automatic settle2();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic measure_relock(input logic [15:0] n, input string req);
    int cnt;
    mode = 2'd1; pin = 1'b0; relock = n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({req, " shutdown all off"}, dut_vec(), model(2'd1, 1'b0));
    pin = 1'b1;
    settle2();
    cnt = 0;
    while (rwait && cnt < 100) begin
      cnt++;
      check({req, " oe quiet in wait"}, 32'(out_oe), 32'd0);
      @(posedge clk); @(negedge clk);
    end
    check({req, " wait length"}, 32'(cnt), 32'(n));
    check({req, " released after wait"}, 32'(out_oe), 32'(out_cfg));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    logic [10:0] r;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; pin = 1'b1; mode = 2'd0;
    out_cfg = 3'b111; pll_cfg = 3'b111; pll_mask = '0; out_mask = '0;
    src = '0; relock = 16'd4;
    repeat (3) @(negedge clk);
    check("R8 reset holds pin low", 32'(out_oe), 32'd0);
    check("R6 reset no error", 32'(cfg_err), 32'd0);
    rst_n = 1'b1;
    settle2();
    check("R7 pin high restores", dut_vec(), model(2'd0, 1'b1));

    // R8 latency: one edge not enough, two edges are
    pin = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 after one edge", 32'(out_oe), 32'h7);
    @(posedge clk); @(negedge clk);
    check("R8 after two edges", 32'(out_oe), 32'h0);
    check("R1 oe mode low", dut_vec(), model(2'd0, 1'b0));
    mode = 2'd3; @(negedge clk);
    check("R1 reserved mode as oe", dut_vec(), model(2'd0, 1'b0));

    // R2/R3 relock windows
    measure_relock(16'd5, "R3 n=5");
    measure_relock(16'd0, "R3 n=0");
    measure_relock(16'd1, "R3 n=1");

    // R5/R6 directed dependency
    mode = 2'd2; src = {2'd0, 2'd2, 2'd1}; pll_mask = 3'b001; out_mask = 3'b000;
    pin = 1'b0; settle2();
    check("R6 violation flagged", 32'(cfg_err), 32'd1);
    check("R5 forced suspend", 32'(out_oe), 32'b110);
    check("R4 pll masked", 32'(pll_en), 32'b110);
    out_mask = 3'b001; @(negedge clk);
    check("R6 consistent mask clears error", 32'(cfg_err), 32'd0);
    pll_mask = 3'b010; out_mask = 3'b000; @(negedge clk);
    check("R5 pll1 forces out1", 32'(out_oe), 32'b101);
    mode = 2'd0; @(negedge clk);
    check("R6 no error outside suspend", 32'(cfg_err), 32'd0);
    mode = 2'd2; pin = 1'b1; settle2();
    check("R7 suspend pin high restores", dut_vec(), model(2'd2, 1'b1));

    // random configurations
    for (int it = 0; it < 400; it++) begin
      mode = 2'($urandom); pin = 1'($urandom);
      out_cfg = 3'($urandom); pll_cfg = 3'($urandom);
      pll_mask = 3'($urandom); out_mask = 3'($urandom);
      src = 6'($urandom); relock = 16'($urandom % 8);
      repeat (12) @(posedge clk);
      @(negedge clk);
      r = model(mode, pin);
      check("R4 R5 R6 R7 random", dut_vec(), r);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule